// File: doc/BRIEF.md
# Multithreaded Register Context Selector

This block keeps one architectural register set for each of several hardware threads in a single register array. A context pointer chooses which thread's set the two read ports see. The same pointer is the thread ID that issues in the current cycle. Changing the pointer selects another register set directly, so a thread switch adds no dead cycles. The single write port carries its own thread ID, because a result that retires late may belong to a thread that is no longer selected.

The next pointer is chosen from per-thread stall flags under one of two policies. In interleaved mode the pointer moves every cycle in round-robin order, starting from the thread after the current one, and it passes over stalled threads. In switch-on-long-stall mode the pointer stays on the current thread until that thread raises a long-stall indication. The pointer then moves to the next thread, in the same rotation, that is not stalled. When no thread can be chosen, the pointer holds and a no-issue flag is raised for the coming cycle.

Top module: `mt_ctx_regfile`

## Requirements
- R1: While reset is asserted and after it is released, `cur_thr` is 0, `no_issue` is 0 and every register of every context reads 0.
- R2: Read ports return the register at `{cur_thr, rd_addr}`. Each thread's registers are separate, so a write to one thread never changes what another thread reads.
- R3: When `wr_en` is high, `wr_data` is stored at the clock edge into register `wr_addr` of thread `wr_thr`, whatever the value of `cur_thr`.
- R4: When `wr_en` is high, `wr_thr` equals `cur_thr` and `wr_addr` equals a read address, that read port returns `wr_data` in the same cycle. A write to another thread is not forwarded.
- R5: With `coarse_mode` at 0, the next `cur_thr` is the first thread with a clear `thr_stall` bit, searching (cur+1), (cur+2) and so on modulo the thread count. The current thread is tried last. `no_issue` is then 0.
- R6: With `coarse_mode` at 0 and all `thr_stall` bits set, `cur_thr` holds and `no_issue` becomes 1.
- R7: With `coarse_mode` at 1 and `long_stall` at 0, `cur_thr` holds and `no_issue` is 0, whatever the `thr_stall` bits are.
- R8: With `coarse_mode` at 1 and `long_stall` at 1, the next `cur_thr` is the first thread other than the current one with a clear `thr_stall` bit, in the order (cur+1), (cur+2) and so on. If there is none, `cur_thr` holds and `no_issue` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_mode | input | 1 | 0: switch thread every cycle; 1: switch only on long stall |
| thr_stall | input | NTHR | Per-thread stall flags, bit i for thread i |
| long_stall | input | 1 | Current thread reports a long-latency stall |
| rd_addr_a | input | log2(NREG) | Read port A register index |
| rd_addr_b | input | log2(NREG) | Read port B register index |
| rd_data_a | output | W | Read port A data from the selected context |
| rd_data_b | output | W | Read port B data from the selected context |
| wr_en | input | 1 | Write enable |
| wr_thr | input | log2(NTHR) | Thread whose context is written |
| wr_addr | input | log2(NREG) | Register index written |
| wr_data | input | W | Write data |
| cur_thr | output | log2(NTHR) | Context pointer: the thread issuing this cycle |
| no_issue | output | 1 | No thread issues this cycle |

## Verification
A write and a read can land on the same register of the active context in the same cycle. At the same time, the pointer that decides which context is "active" can be about to change. The bench holds the pointer with the long-stall policy and drives a write to the selected thread at the address both read ports use. It checks the forwarded value before the edge and the stored value after it. It also drives a write to the next thread at the same address and confirms that the read still returns the old value of the selected context, and that the other thread holds the new one. The selection policy is swept over every stall mask, both modes, both long-stall levels and every starting pointer. Each result is compared against an arithmetic rotation model.

// File: rtl/mt_ctx_regfile.sv
module mt_ctx_regfile #(
  parameter int NTHR = 4,
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int TW  = $clog2(NTHR),
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coarse_mode,
  input  logic [NTHR-1:0] thr_stall,
  input  logic          long_stall,
  input  logic [RW-1:0] rd_addr_a,
  input  logic [RW-1:0] rd_addr_b,
  output logic [W-1:0]  rd_data_a,
  output logic [W-1:0]  rd_data_b,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_thr,
  input  logic [RW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [TW-1:0] cur_thr,
  output logic          no_issue
);

  localparam int NENT = NTHR * NREG;

  logic [W-1:0]  ctx [NENT];
  logic [TW-1:0] ptr_q, ptr_d, cand;
  logic          idle_q, idle_d, found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) ctx[i] <= '0;
    end else if (wr_en) begin
      ctx[{wr_thr, wr_addr}] <= wr_data;
    end
  end

  wire hit_a = wr_en && (wr_thr == ptr_q) && (wr_addr == rd_addr_a);
  wire hit_b = wr_en && (wr_thr == ptr_q) && (wr_addr == rd_addr_b);

  assign rd_data_a = hit_a ? wr_data : ctx[{ptr_q, rd_addr_a}];
  assign rd_data_b = hit_b ? wr_data : ctx[{ptr_q, rd_addr_b}];

  always_comb begin
    ptr_d  = ptr_q;
    idle_d = 1'b0;
    found  = 1'b0;
    cand   = '0;
    if (!coarse_mode) begin
      for (int k = 1; k <= NTHR; k++) begin
        cand = ptr_q + TW'(k);
        if (!found && !thr_stall[cand]) begin
          ptr_d = cand;
          found = 1'b1;
        end
      end
      idle_d = !found;
    end else if (long_stall) begin
      for (int k = 1; k < NTHR; k++) begin
        cand = ptr_q + TW'(k);
        if (!found && !thr_stall[cand]) begin
          ptr_d = cand;
          found = 1'b1;
        end
      end
      idle_d = !found;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      idle_q <= idle_d;
    end
  end

  assign cur_thr  = ptr_q;
  assign no_issue = idle_q;

endmodule

// File: rtl/mt_ctx_regfile_chk.sv
module mt_ctx_regfile_chk #(
  parameter int NTHR = 4,
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int TW  = $clog2(NTHR),
  localparam int RW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          coarse_mode,
  input logic [NTHR-1:0] thr_stall,
  input logic          long_stall,
  input logic [RW-1:0] rd_addr_a,
  input logic [RW-1:0] rd_addr_b,
  input logic [W-1:0]  rd_data_a,
  input logic [W-1:0]  rd_data_b,
  input logic          wr_en,
  input logic [TW-1:0] wr_thr,
  input logic [RW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic [TW-1:0] cur_thr,
  input logic          no_issue
);

  logic [TW-1:0] nxt1;
  assign nxt1 = cur_thr + TW'(1);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cur_thr == '0) && !no_issue);

  a_r4_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_thr == cur_thr && wr_addr == rd_addr_a) |-> rd_data_a == wr_data);

  a_r4_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_thr == cur_thr && wr_addr == rd_addr_b) |-> rd_data_b == wr_data);

  a_r5_rotate_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_mode && !thr_stall[nxt1]) |=> (cur_thr == $past(nxt1)) && !no_issue);

  a_r6_all_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_mode && (&thr_stall)) |=> $stable(cur_thr) && no_issue);

  a_r7_coarse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_mode && !long_stall) |=> $stable(cur_thr) && !no_issue);

  a_r8_coarse_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_mode && long_stall) |=> (cur_thr != $past(cur_thr)) || no_issue);

endmodule

bind mt_ctx_regfile mt_ctx_regfile_chk #(.NTHR(NTHR), .NREG(NREG), .W(W)) u_chk (.*);

// File: tb/tb_mt_ctx_regfile.sv
module tb_mt_ctx_regfile;
  localparam int CLK_P = 10;
  localparam int NT = 4;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coarse_mode = 1'b0;
  logic [3:0]  thr_stall = '0;
  logic        long_stall = 1'b0;
  logic [2:0]  rd_addr_a = '0, rd_addr_b = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_thr = '0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  cur_thr;
  logic        no_issue;

  int nchk = 0, nfail = 0;
  bit done = 0;

  mt_ctx_regfile dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] pat(input int t, input int r);
    return 32'hA500_0000 | (t << 8) | r;
  endfunction

  function automatic logic [2:0] model(input int cur, input logic [3:0] st, input bit crs, input bit ls);
    int lim;
    if (crs && !ls) return {1'b0, 2'(cur)};
    lim = crs ? NT - 1 : NT;
    for (int k = 1; k <= lim; k++) begin
      int c = (cur + k) % NT;
      if (!st[c]) return {1'b0, 2'(c)};
    end
    return {1'b1, 2'(cur)};
  endfunction

  task automatic sel(input int p);
    coarse_mode = 1'b0; long_stall = 1'b0;
    thr_stall = ~(4'b1 << p);
    step();
    chk(cur_thr == 2'(p) && !no_issue, "R5 select", {30'b0, cur_thr}, p);
    coarse_mode = 1'b1;
    thr_stall = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 1);
    chk(cur_thr == 0 && !no_issue, "R1 reset ptr", {29'b0, no_issue, cur_thr}, 0);
    rst_n = 1'b1;
    coarse_mode = 1'b1;
    step();
    chk(cur_thr == 0 && !no_issue, "R1 after release", {29'b0, no_issue, cur_thr}, 0);

    for (int p = 0; p < NT; p++) begin
      sel(p);
      for (int r = 0; r < NR; r++) begin
        rd_addr_a = 3'(r); rd_addr_b = 3'(7 - r); #1;
        chk(rd_data_a == 0 && rd_data_b == 0, "R1 regs zero", rd_data_a | rd_data_b, 0);
      end
    end

    coarse_mode = 1'b0; thr_stall = '0;
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < NR; r++) begin
        wr_en = 1'b1; wr_thr = 2'(t); wr_addr = 3'(r); wr_data = pat(t, r);
        step();
      end
    wr_en = 1'b0;

    for (int p = 0; p < NT; p++) begin
      sel(p);
      for (int r = 0; r < NR; r++) begin
        rd_addr_a = 3'(r); rd_addr_b = 3'(r ^ 5); #1;
        chk(rd_data_a == pat(p, r), "R2 R3 read a", rd_data_a, pat(p, r));
        chk(rd_data_b == pat(p, r ^ 5), "R2 R3 read b", rd_data_b, pat(p, r ^ 5));
      end
    end

    sel(2);
    for (int r = 0; r < NR; r++) begin
      rd_addr_a = 3'(r); rd_addr_b = 3'(r);
      wr_en = 1'b1; wr_thr = 2'd3; wr_addr = 3'(r); wr_data = pat(3, r) ^ 32'h0F0F;
      #1;
      chk(rd_data_a == pat(2, r), "R4 R2 no cross-thread bypass", rd_data_a, pat(2, r));
      step();
      wr_thr = 2'd2; wr_data = pat(2, r) ^ 32'hFFFF_0000;
      #1;
      chk(rd_data_a == wr_data, "R4 bypass a", rd_data_a, wr_data);
      chk(rd_data_b == wr_data, "R4 bypass b", rd_data_b, wr_data);
      chk(cur_thr == 2'd2, "R7 hold during writes", {30'b0, cur_thr}, 2);
      step();
    end
    wr_en = 1'b0;
    for (int r = 0; r < NR; r++) begin
      rd_addr_a = 3'(r); #1;
      chk(rd_data_a == (pat(2, r) ^ 32'hFFFF_0000), "R3 committed own", rd_data_a, pat(2, r) ^ 32'hFFFF_0000);
    end
    sel(3);
    for (int r = 0; r < NR; r++) begin
      rd_addr_a = 3'(r); #1;
      chk(rd_data_a == (pat(3, r) ^ 32'h0F0F), "R3 committed other", rd_data_a, pat(3, r) ^ 32'h0F0F);
    end

    for (int p = 0; p < NT; p++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 16; s++) begin
          logic [2:0] e;
          string tag;
          sel(p);
          coarse_mode = m[1]; long_stall = m[0]; thr_stall = 4'(s);
          e = model(p, 4'(s), m[1], m[0]);
          if (!m[1]) tag = (s == 15) ? "R6 all stalled" : "R5 round robin";
          else tag = m[0] ? "R8 long stall switch" : "R7 coarse hold";
          step();
          chk({no_issue, cur_thr} == e, tag, {29'b0, no_issue, cur_thr}, {29'b0, e});
        end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule